// File: doc/BRIEF.md
# Interlaced Row Scan Sequencer

This block drives the control inputs of a chain of cascaded row-scan shift registers for a matrix-addressed display. A main board supplies a line address whose least significant bit completes one period per 64 µs line, plus a field parity level that flips at the start of every field. The block brings both into the system clock domain. It forwards the low address bit as the shift clock of the chain. It places a single active bit on the serial scan input at the first line of each field, so the chain walks that bit from the first row to the last, one row per line.

A line counter, restarted by every parity change, decides when the scan bit is raised and when it falls back. The counter stops at the number of rows in the frame, so extra line edges inside a long field cannot inject a second token. The parity level, once synchronised, is also presented as the chain's clear control. The strobe, polarity, blanking and shift-direction controls of the chain are fixed levels chosen by parameters.

Top module: `row_scan_seq`

## Requirements
- R1: `shift_clk` equals bit 0 of `line_addr` as sampled two system clock edges earlier (two-flop synchroniser, no other logic).
- R2: The first rising edge of bit 0 of `line_addr` in a field sets `scan_bit` to 1. It becomes visible after the third system clock edge following the input change, which is one edge after `shift_clk` rises.
- R3: `scan_bit` returns to 0 at the second rising edge of bit 0 in the same field, with the same latency as R2, and stays 0 for the rest of the field.
- R4: The line counter stops at `LINES` rising edges per field. However many further edges arrive, no second token is injected within the field.
- R5: Any change of `field_par`, in either direction, restarts the field: the counter returns to 0 and `scan_bit` to 0 after the third edge following the change, and the next rising edge of bit 0 injects again. Both field parities inject.
- R6: `chain_clr` equals `field_par` delayed by three system clock edges (0 while parity is low, 1 while it is high).
- R7: Bits `ADDR_W-1` down to 1 of `line_addr` have no effect on any output.
- R8: `strobe`, `polarity`, `blank` and `shift_dir` equal the parameters `STB_LVL`, `POL_LVL`, `BLK_LVL` and `DIR_LVL` at all times.
- R9: While `rst_n` is low, `scan_bit`, `shift_clk` and `chain_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_addr | input | ADDR_W | Line address from the main board; bit 0 is the line clock |
| field_par | input | 1 | Field parity level |
| scan_bit | output | 1 | Serial scan input of the first shift register |
| shift_clk | output | 1 | Shift clock of the chain |
| chain_clr | output | 1 | Clear control of the chain, follows field parity |
| strobe | output | 1 | Fixed latch strobe level |
| polarity | output | 1 | Fixed output polarity level |
| blank | output | 1 | Fixed blanking level |
| shift_dir | output | 1 | Fixed shift direction level |

## Verification
The bench builds the block with `ADDR_W = 4` and `LINES = 6`, so the counter is three bits wide. Fields of up to 13 lines therefore pass both the saturation point and the point where a wrapping counter would return to zero and inject a second token. Ten fields of varying length alternate the parity, including a one-line field that clears a live token. The three upper address bits are swept through all their values, both during lines and with the line clock held still.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    // Edge information of one synchronised level
    typedef struct packed {
        logic rise;
        logic chg;
    } edge_t;

endpackage

// File: rtl/scan_sync2.sv
module scan_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/scan_edge_det.sv
module scan_edge_det
    import row_scan_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output edge_t        ev   [W],
    output logic [W-1:0] lvl_dly
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_ev
        assign ev[i].rise = lvl[i] & ~prev_q[i];
        assign ev[i].chg  = lvl[i] ^ prev_q[i];
    end

    assign lvl_dly = prev_q;
endmodule

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
    parameter int LINES = 480,
    parameter int CNT_W = $clog2(LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_rise,
    input  logic             field_chg,
    output logic             scan,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LINES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             scan;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (field_chg) begin
            // a new field restarts injection; a coincident line edge is dropped
            st_d.cnt  = '0;
            st_d.scan = 1'b0;
        end else if (line_rise && (st_q.cnt < LIMIT)) begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.scan = (st_q.cnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scan = st_q.scan;
    assign cnt  = st_q.cnt;
endmodule

// File: rtl/row_scan_seq.sv
module row_scan_seq
    import row_scan_pkg::*;
#(
    parameter int   ADDR_W  = 8,
    parameter int   LINES   = 480,
    parameter logic STB_LVL = 1'b1,
    parameter logic POL_LVL = 1'b0,
    parameter logic BLK_LVL = 1'b1,
    parameter logic DIR_LVL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic              field_par,
    output logic              scan_bit,
    output logic              shift_clk,
    output logic              chain_clr,
    output logic              strobe,
    output logic              polarity,
    output logic              blank,
    output logic              shift_dir
);
    localparam int CNT_W = $clog2(LINES + 1);
    localparam int NSIG  = 2;
    localparam int I_LN  = 0;
    localparam int I_FP  = 1;

    logic [NSIG-1:0]  raw_lvl, sync_lvl, dly_lvl;
    edge_t            ev [NSIG];
    logic [CNT_W-1:0] line_cnt;
    logic             unused_hi;
    logic             unused_ev;

    assign raw_lvl[I_LN] = line_addr[0];
    assign raw_lvl[I_FP] = field_par;

    scan_sync2 #(.W(NSIG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lvl),
        .dout  (sync_lvl)
    );

    scan_edge_det #(.W(NSIG)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (sync_lvl),
        .ev      (ev),
        .lvl_dly (dly_lvl)
    );

    scan_line_ctr #(.LINES(LINES), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_rise (ev[I_LN].rise),
        .field_chg (ev[I_FP].chg),
        .scan      (scan_bit),
        .cnt       (line_cnt)
    );

    // shift clock leads the scan bit by one system clock: hold margin for the chain
    assign shift_clk = sync_lvl[I_LN];
    assign chain_clr = dly_lvl[I_FP];

    assign strobe    = STB_LVL;
    assign polarity  = POL_LVL;
    assign blank     = BLK_LVL;
    assign shift_dir = DIR_LVL;

    // upper address bits and spare edge flags carry no function here
    assign unused_hi = ^line_addr[ADDR_W-1:1];
    assign unused_ev = ev[I_LN].chg ^ ev[I_FP].rise ^ dly_lvl[I_LN];
endmodule

// File: rtl/row_scan_seq_chk.sv
module row_scan_seq_chk #(
    parameter int LINES = 480,
    parameter int CNT_W = $clog2(LINES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lsb_in,
    input logic             scan_bit,
    input logic             shift_clk,
    input logic             chain_clr,
    input logic [CNT_W-1:0] line_cnt
);
    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    p_clk_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (shift_clk == $past(lsb_in, 2)));

    p_inject_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_bit) |-> ($past(shift_clk) && !$past(shift_clk, 2) && line_cnt == CNT_W'(1)));

    p_token_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_bit |-> (line_cnt == CNT_W'(1)));

    p_cnt_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt <= CNT_W'(LINES));

    p_field_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_clr) |-> (line_cnt == '0 && !scan_bit));

    p_drop_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_bit) |-> (($past(shift_clk) && !$past(shift_clk, 2)) || !$stable(chain_clr)));
endmodule

bind row_scan_seq row_scan_seq_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lsb_in    (line_addr[0]),
    .scan_bit  (scan_bit),
    .shift_clk (shift_clk),
    .chain_clr (chain_clr),
    .line_cnt  (line_cnt)
);

// File: tb/tb_row_scan_seq.sv
module tb_row_scan_seq;
    localparam int   ADDR_W = 4;
    localparam int   LINES  = 6;
    localparam logic STB    = 1'b1;
    localparam logic POL    = 1'b0;
    localparam logic BLK    = 1'b1;
    localparam logic DIR    = 1'b0;
    localparam int   WDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] line_addr = '0;
    logic              field_par = 1'b0;
    logic scan_bit, shift_clk, chain_clr, strobe, polarity, blank, shift_dir;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int k_lines  = 0;     // rising line edges seen in current field
    logic exp_scan = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    row_scan_seq #(
        .ADDR_W(ADDR_W), .LINES(LINES),
        .STB_LVL(STB), .POL_LVL(POL), .BLK_LVL(BLK), .DIR_LVL(DIR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .line_addr(line_addr), .field_par(field_par),
        .scan_bit(scan_bit), .shift_clk(shift_clk), .chain_clr(chain_clr),
        .strobe(strobe), .polarity(polarity), .blank(blank), .shift_dir(shift_dir)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_fixed();
        chk(strobe == STB && polarity == POL && blank == BLK && shift_dir == DIR, "R8 fixed",
            {strobe, polarity, blank, shift_dir}, {STB, POL, BLK, DIR});
    endtask

    // one full line: rising then falling bit 0, upper bits set to hi
    task automatic do_line(input logic [ADDR_W-2:0] hi);
        logic old_scan;
        old_scan = exp_scan;
        @(negedge clk) line_addr = {hi, 1'b1};
        repeat (2) @(posedge clk);
        #2;
        chk(shift_clk == 1'b1, "R1 shift_clk high", shift_clk, 1);
        chk(scan_bit == old_scan, "R2 scan waits one edge", scan_bit, old_scan);
        k_lines++;
        exp_scan = (k_lines == 1);
        @(posedge clk);
        #2;
        if (k_lines == 1)
            chk(scan_bit == exp_scan, "R2 inject", scan_bit, exp_scan);
        else if (k_lines <= LINES)
            chk(scan_bit == exp_scan, "R3 token gone", scan_bit, exp_scan);
        else
            chk(scan_bit == exp_scan, "R4 saturated no reinject", scan_bit, exp_scan);
        chk(chain_clr == field_par, "R6 clear level", chain_clr, field_par);
        repeat (3) @(posedge clk);
        @(negedge clk) line_addr = {hi, 1'b0};
        repeat (2) @(posedge clk);
        #2;
        chk(shift_clk == 1'b0, "R1 shift_clk low", shift_clk, 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic new_field(input logic p);
        @(negedge clk) field_par = p;
        repeat (2) @(posedge clk);
        #2;
        chk(chain_clr == ~p, "R6 clear not early", chain_clr, ~p);
        @(posedge clk);
        #2;
        chk(chain_clr == p, "R6 clear follows parity", chain_clr, p);
        chk(scan_bit == 1'b0, "R5 restart clears scan", scan_bit, 0);
        k_lines  = 0;
        exp_scan = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin : watchdog
        while (!done && cyc < WDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // R9 reset state, with inputs pushed high during reset
        @(negedge clk) begin line_addr = '1; field_par = 1'b1; end
        repeat (4) @(posedge clk);
        #2;
        chk(scan_bit == 0 && shift_clk == 0 && chain_clr == 0, "R9 reset outputs",
            {scan_bit, shift_clk, chain_clr}, 0);
        chk_fixed();
        @(negedge clk) begin line_addr = '0; field_par = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        chk(scan_bit == 0 && chain_clr == 0, "R9 idle after reset", {scan_bit, chain_clr}, 0);

        // R2 R3 R4 R5 R6: ten fields of varied length, alternating parity
        for (int f = 0; f < 10; f++) begin
            int nl;
            nl = ((f * 5) % 13) + 1;
            if (f != 0) new_field(logic'(f % 2));
            for (int l = 0; l < nl; l++)
                do_line(3'((l * 3 + f) % 8));
            chk_fixed();
        end

        // R5: one-line field then parity change while token is live
        new_field(1'b0);
        do_line(3'd5);
        chk(scan_bit == 1'b1, "R5 token live before flip", scan_bit, 1);
        new_field(1'b1);
        do_line(3'd2);
        chk(scan_bit == 1'b1, "R5 reinject after flip", scan_bit, 1);

        // R7: upper bits swept with bit 0 still, nothing moves
        for (int h = 0; h < 8; h++) begin
            @(negedge clk) line_addr = {3'(h), 1'b0};
            repeat (4) @(posedge clk);
            #2;
            chk(shift_clk == 0 && scan_bit == exp_scan && chain_clr == 1'b1, "R7 upper bits ignored",
                {shift_clk, scan_bit, chain_clr}, {1'b0, exp_scan, 1'b1});
        end
        do_line(3'd7);
        chk(scan_bit == 1'b0, "R7 R3 count unaffected by upper bits", scan_bit, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule